// File: doc/BRIEF.md
# Parallel I/O Port with Edge Capture

A general-purpose parallel I/O port of up to 32 pins, controlled through four word registers on a simple memory-mapped slave bus. Each pin has its own direction bit. A pin set as an output drives the value held in an output latch. A pin set as an input is sampled through a two-stage synchroniser, and software reads the sampled values back.

The trigger kind is fixed by a parameter at elaboration: level-high, rising edge, falling edge or both edges. In the edge kinds, each detected edge sets a sticky bit in a capture register. Software clears those bits by writing ones to them. A single interrupt line combines every pin, gated by a per-pin enable mask.

The parent design connects `pin_out` and `pin_oe` to its tri-state pad logic and feeds the pad input values into `pin_in`.

Top module: `pio_edge_port`

## Requirements
- R1: After reset the direction register, enable mask, capture register and output latch read as zero, `pin_oe` and `pin_out` are all zero, and `irq` is low.
- R2: A read of word 0 (data) returns the synchronised `pin_in` values. A change on `pin_in` shows in the read value after two rising clock edges.
- R3: A write to word 0 loads the output latch, which `pin_out` presents. `pin_oe` equals the direction register, where bit value 1 means output and 0 means input. A write to word 1 updates `pin_oe` on the next edge.
- R4: Words 1 (direction) and 2 (enable mask, where 1 enables the pin's interrupt) read back the last value written to them. Register bits at positions of PINS and above read as zero.
- R5: With TRIG=1 only a 0-to-1 transition of a synchronised pin sets its capture bit. TRIG=2 captures only 1-to-0 transitions, and TRIG=3 captures both. A capture bit stays set until it is cleared. It becomes readable three edges after the pin changes.
- R6: A write to word 3 (capture) clears every capture bit written as 1. Bits written as 0 keep their value.
- R7: If a new edge is detected on a pin in the same cycle that a write clears that pin's capture bit, the bit ends up set.
- R8: In the edge kinds, `irq` is high exactly while the AND of the capture register and the mask is nonzero.
- R9: With TRIG=0 (level-high), `irq` is high exactly while the AND of the synchronised pins and the mask is nonzero. In this kind the capture register always reads zero.
- R10: Register selection uses a 2-bit word index: 0 data, 1 direction, 2 mask, 3 capture. `rdata` is zero whenever `rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Word index of the register accessed |
| rd | input | 1 | Read strobe; gates `rdata` |
| wr | input | 1 | Write strobe, taken on the rising edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| pin_in | input | PINS | Pad input values |
| pin_out | output | PINS | Output latch value toward the pads |
| pin_oe | output | PINS | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The capture register has two update sources: a synchronised edge and a software clear. Both can act in the same cycle. The bench provokes this by changing a pin two edges before a write that clears that pin's bit and, in the same write, another already-captured bit. Readback must show that the pin with the fresh edge stays set and the other bit is cleared. The rule that the edge wins also gates the interrupt, so the enabled line must stay high through that clear.

// File: rtl/pio_edge_port.sv
module pio_edge_port #(
  parameter int PINS = 32,
  parameter int TRIG = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      addr,
  input  logic            rd,
  input  logic            wr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic            irq
);
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_DIR  = 2'd1;
  localparam logic [1:0] A_MASK = 2'd2;
  localparam logic [1:0] A_CAP  = 2'd3;

  logic [PINS-1:0] sync1, sync2, prev;
  logic [PINS-1:0] out_q, dir_q, mask_q, cap_q;
  logic [PINS-1:0] hit, clr;

  generate
    if (TRIG == 1) begin : g_rise
      assign hit = sync2 & ~prev;
    end else if (TRIG == 2) begin : g_fall
      assign hit = ~sync2 & prev;
    end else if (TRIG == 3) begin : g_both
      assign hit = sync2 ^ prev;
    end else begin : g_level
      assign hit = '0;
    end
  endgenerate

  assign clr = (wr && addr == A_CAP) ? wdata[PINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      prev   <= '0;
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
      cap_q  <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      prev  <= sync2;
      if (wr && addr == A_DATA) out_q  <= wdata[PINS-1:0];
      if (wr && addr == A_DIR)  dir_q  <= wdata[PINS-1:0];
      if (wr && addr == A_MASK) mask_q <= wdata[PINS-1:0];
      cap_q <= (cap_q & ~clr) | hit;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (addr)
        A_DATA:  rdata = 32'(sync2);
        A_DIR:   rdata = 32'(dir_q);
        A_MASK:  rdata = 32'(mask_q);
        default: rdata = 32'(cap_q);
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  generate
    if (TRIG == 0) begin : g_irq_level
      assign irq = |(sync2 & mask_q);
    end else begin : g_irq_edge
      assign irq = |(cap_q & mask_q);
    end
  endgenerate
endmodule

module pio_edge_port_chk #(
  parameter int PINS = 32,
  parameter int TRIG = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      addr,
  input logic            wr,
  input logic [31:0]     wdata,
  input logic [PINS-1:0] pin_oe,
  input logic [PINS-1:0] mask_q,
  input logic [PINS-1:0] cap_q,
  input logic [PINS-1:0] hit,
  input logic            irq
);
  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd1) |=> (pin_oe == $past(wdata[PINS-1:0]))); // R3
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd2) |=> (mask_q == $past(wdata[PINS-1:0]))); // R4
  AST_CAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == 2'd3) |=> ((cap_q & $past(cap_q)) == $past(cap_q))); // R5
  AST_CAP_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd3) |=> ((cap_q & $past(wdata[PINS-1:0]) & ~$past(hit)) == '0)); // R6
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((cap_q & $past(hit)) == $past(hit))); // R7
  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq); // R8
  AST_LEVEL_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (TRIG == 0) |-> (cap_q == '0)); // R9
endmodule

bind pio_edge_port pio_edge_port_chk #(.PINS(PINS), .TRIG(TRIG)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .wdata(wdata),
  .pin_oe(pin_oe), .mask_q(mask_q), .cap_q(cap_q), .hit(hit), .irq(irq)
);

// File: tb/test_pio_edge_port.sv
module test_pio_edge_port;
  logic clk = 0, rst_n = 0, rd = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, pins = 0;
  logic [31:0] rd_m, rd_f, rd_b, rd_l;
  logic [31:0] po_m, oe_m;
  logic [7:0] po_f, oe_f, po_b, oe_b, po_l, oe_l;
  logic irq_m, irq_f, irq_b, irq_l;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  pio_edge_port #(.PINS(32), .TRIG(1)) i_pio_edge_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rd_m), .pin_in(pins), .pin_out(po_m), .pin_oe(oe_m), .irq(irq_m));
  pio_edge_port #(.PINS(8), .TRIG(2)) i_fall (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rd_f), .pin_in(pins[7:0]), .pin_out(po_f), .pin_oe(oe_f), .irq(irq_f));
  pio_edge_port #(.PINS(8), .TRIG(3)) i_both (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rd_b), .pin_in(pins[7:0]), .pin_out(po_b), .pin_oe(oe_b), .irq(irq_b));
  pio_edge_port #(.PINS(8), .TRIG(0)) i_lvl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rd_l), .pin_in(pins[7:0]), .pin_out(po_l), .pin_oe(oe_l), .irq(irq_l));

  localparam logic [1:0] OP_WR = 0, OP_RD = 1, OP_PIN = 2, OP_IRQ = 3;

  function automatic logic [71:0] mk(input logic [3:0] r, input logic [1:0] op,
                                     input logic [1:0] a, input logic [31:0] d,
                                     input logic [31:0] e);
    return {r, op, a, d, e};
  endfunction

  localparam logic [71:0] VEC [32] = '{
    mk(2,  OP_RD,  0, 0, 0),                        // R2 data reads idle pins
    mk(1,  OP_RD,  1, 0, 0),                        // R1 direction reset
    mk(1,  OP_RD,  2, 0, 0),                        // R1 mask reset
    mk(1,  OP_RD,  3, 0, 0),                        // R1 capture reset
    mk(4,  OP_WR,  1, 32'h0000_FFFF, 0),
    mk(4,  OP_RD,  1, 0, 32'h0000_FFFF),            // R4 direction readback
    mk(4,  OP_WR,  2, 32'h5, 0),
    mk(10, OP_RD,  2, 0, 32'h5),                    // R10 mask at word 2
    mk(4,  OP_WR,  2, 0, 0),
    mk(2,  OP_PIN, 0, 32'h0000_0011, 0),
    mk(2,  OP_RD,  0, 0, 32'h0000_0011),            // R2 sampled pins
    mk(5,  OP_RD,  3, 0, 32'h0000_0011),            // R5 rising captured
    mk(5,  OP_PIN, 0, 32'h0000_0001, 0),
    mk(5,  OP_RD,  3, 0, 32'h0000_0011),            // R5 falling ignored, sticky
    mk(6,  OP_WR,  3, 32'h1, 0),
    mk(6,  OP_RD,  3, 0, 32'h0000_0010),            // R6 written one clears only
    mk(8,  OP_IRQ, 0, 0, 0),                        // R8 mask zero
    mk(8,  OP_WR,  2, 32'h10, 0),
    mk(8,  OP_IRQ, 0, 0, 1),                        // R8 enabled capture
    mk(6,  OP_WR,  3, 32'h10, 0),
    mk(6,  OP_IRQ, 0, 0, 0),                        // R6 clear drops irq
    mk(6,  OP_RD,  3, 0, 0),
    mk(5,  OP_PIN, 0, 32'h8000_0001, 0),
    mk(5,  OP_RD,  3, 0, 32'h8000_0000),            // R5 top pin
    mk(8,  OP_IRQ, 0, 0, 0),                        // R8 masked capture
    mk(8,  OP_WR,  2, 32'h8000_0000, 0),
    mk(8,  OP_IRQ, 0, 0, 1),
    mk(6,  OP_WR,  3, 32'hFFFF_FFFF, 0),
    mk(6,  OP_RD,  3, 0, 0),
    mk(8,  OP_IRQ, 0, 0, 0),
    mk(5,  OP_PIN, 0, 32'h0, 0),
    mk(5,  OP_RD,  3, 0, 0)                         // R5 falls not captured
  };

  task automatic check(input int r, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d %s: got %h expected %h", r, what, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a);
    @(negedge clk); addr = a; rd = 1; #1;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk); pins = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(1, "irq after reset", 32'(irq_m), 0);
    check(1, "oe after reset", oe_m, 0);

    for (int i = 0; i < 32; i++) begin
      logic [71:0] v;
      v = VEC[i];
      case (v[67:66])
        OP_WR:  bus_wr(v[65:64], v[63:32]);
        OP_PIN: set_pins(v[63:32]);
        OP_RD: begin
          bus_rd(v[65:64]);
          check(int'(v[71:68]), $sformatf("vec %0d read", i), rd_m, v[31:0]);
          rd = 0;
        end
        default: begin
          @(negedge clk); #1;
          check(int'(v[71:68]), $sformatf("vec %0d irq", i), 32'(irq_m), v[31:0]);
        end
      endcase
    end

    // R3 output latch and enables
    bus_wr(1, 32'h0000_00F0);
    bus_wr(0, 32'h0000_00FF);
    #1;
    check(3, "pin_oe", oe_m, 32'h0000_00F0);
    check(3, "pin_out", po_m, 32'h0000_00FF);
    bus_rd(0);
    check(2, "data read ignores latch", rd_m, 0);
    rd = 0;
    check(10, "rdata idle without rd", rd_m, 0);

    // R1 reset clears state
    bus_wr(2, 32'hFFFF_FFFF);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; #1;
    check(1, "pin_out after reset", po_m, 0);
    check(1, "pin_oe after reset", oe_m, 0);
    bus_rd(2);
    check(1, "mask after reset", rd_m, 0);
    rd = 0;

    // R5 / R9 other trigger kinds
    set_pins(32'h1);
    bus_rd(3);
    check(5, "falling kind ignores rise", rd_f, 0);
    check(5, "both kind captures rise", rd_b, 32'h1);
    check(9, "level kind capture zero", rd_l, 0);
    rd = 0;
    bus_wr(2, 32'h1);
    #1;
    check(9, "level irq high", 32'(irq_l), 1);
    check(8, "falling kind irq idle", 32'(irq_f), 0);
    set_pins(32'h0);
    check(9, "level irq low", 32'(irq_l), 0);
    check(8, "falling kind irq", 32'(irq_f), 1);
    bus_rd(3);
    check(5, "falling kind captures fall", rd_f, 32'h1);
    rd = 0;

    // R7 edge and clear in the same cycle
    bus_wr(3, 32'hFFFF_FFFF);
    set_pins(32'h2);
    set_pins(32'h0);
    @(negedge clk); pins = 32'h1;
    @(negedge clk);
    @(negedge clk); addr = 3; wdata = 32'h3; wr = 1;
    @(negedge clk); wr = 0;
    bus_rd(3);
    check(7, "edge beats clear", rd_m, 32'h1);
    rd = 0;
    #1;
    check(7, "irq held through clear", 32'(irq_m), 1);

    // R4 narrow port
    bus_wr(1, 32'hFFFF_FFFF);
    bus_rd(1);
    check(4, "upper bits zero", rd_f, 32'h0000_00FF);
    rd = 0;

    finish_run();
  end
endmodule